// File: doc/BRIEF.md
# Program ROM Bank Selector

This block maps the processor's upper address space, from 0x6000 to 0xFFFF, onto program ROM in 8 KB pages. It holds four 8-bit bank registers, a control register and an outer-bank extension value. From these it computes five 8 KB page numbers: one for the window at 0x6000 and one for each of the four slots at 0x8000, 0xA000, 0xC000 and 0xE000. The top three address bits pick which of the five numbers is placed on the ROM bank output.

There are four banking modes. The 32 KB and 16 KB modes switch larger blocks, and the 8 KB page inside each block comes from the slot position. The plain 8 KB mode switches each slot on its own. The fourth mode is also 8 KB, but each bank value is bit-reversed before use. In every mode the window at 0x6000 follows bank register 3. A control bit sets whether the top bank is fixed at all ones or follows bank register 3.

Top module: `prg_bank_sel`

## Requirements
- R1: A synchronous reset with rst_n low clears every register to zero. That selects the 32 KB mode with the top bank at all ones, so slots 0x8000..0xE000 give pages 0x3C..0x3F and the 0x6000 window gives page 0x03.
- R2: A write with wr_en high stores wr_data at the next rising edge. wr_sel 0..3 addresses bank registers 0..3, 4 the control register and 5 the extension value. Codes 6 and 7 change nothing. The output keeps its old value until the edge that stores the write.
- R3: When cpu_addr_top is 0, 1 or 2 (addresses below 0x6000), rom_sel is 0 and rom_bank is 0. For 3..7, rom_sel is 1.
- R4: When control bits 1:0 = 0 (32 KB), let B = (top AND 0x0F) OR (ext >> 2). Slot k (k = 0..3, from address bits 14:13) gives B*4 + k. The 0x6000 window gives ((bank3*4 + 3) AND 0x3F) OR (ext >> 2).
- R5: When control bits 1:0 = 1 (16 KB), let L = (bank1 AND 0x1F) OR (ext >> 1) and H = (top AND 0x1F) OR (ext >> 1). Slots 0x8000 and 0xA000 give L*2 and L*2+1. Slots 0xC000 and 0xE000 give H*2 and H*2+1. The 0x6000 window gives ((bank3*2 + 1) AND 0x1F) OR (ext >> 1).
- R6: When control bits 1:0 = 2 (8 KB), the slots give bank0, bank1, bank2 and top, each ORed with ext. The 0x6000 window gives bank3 OR ext.
- R7: When control bits 1:0 = 3 (reversed 8 KB), each source value v (bank0, bank1, bank2, top, and bank3 for the window) has its bits 6:0 reversed. The result is masked to its low 6 bits and ORed with ext, so result bit i equals v bit 6-i for i = 0..5.
- R8: The top bank equals bank3 when control bit 2 is 1. When control bit 2 is 0, it is 0xFF.
- R9: In every mode the extension value is ORed into the page number at the shift listed above: by 2 in 32 KB mode, by 1 in 16 KB mode, and unshifted in both 8 KB modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0..3 bank, 4 control, 5 extension |
| wr_data | input | 8 | Write data |
| cpu_addr_top | input | 3 | Processor address bits 15:13 |
| rom_sel | output | 1 | Address falls in the banked range 0x6000..0xFFFF |
| rom_bank | output | 8 | 8 KB ROM page number for the current address |

## Verification
A register write becomes visible on the output after exactly one rising edge. The bench drives each write on a falling edge and samples the output two nanoseconds after the next falling edge, once the storing edge has passed. The address path has no register, so rom_bank follows cpu_addr_top in the same cycle, and each lookup is sampled a short delay after the address changes. One directed test samples the output before the storing edge, to confirm the old page still shows until the write is captured.

// File: rtl/prg_bank_pkg.sv
// Package: shared widths, mode encoding and the bit-reversal helper for the
// program ROM bank selector. Assumes 8-bit bank registers.
package prg_bank_pkg;
    localparam int BANK_W  = 8;
    localparam int NSLOT   = 4;
    localparam int SEL_W   = 3;
    localparam int PAGE_W  = 3;
    localparam int NBANK   = 4;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_EXT  = 3'd5;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        MODE_32K    = 2'd0,
        MODE_16K    = 2'd1,
        MODE_8K     = 2'd2,
        MODE_8K_REV = 2'd3
    } prg_mode_e;

    // Reverse the order of the low seven bits.
    function automatic logic [6:0] rev7(input logic [6:0] v);
        logic [6:0] r;
        for (int i = 0; i < 7; i++) begin
            r[i] = v[6-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/prg_bank_regs.sv
// Module: register file of the bank selector. Holds four bank registers,
// the control register and the extension value. Assumes writes arrive as a
// single-cycle strobe; unused select codes are dropped.
module prg_bank_regs
    import prg_bank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [BANK_W-1:0]            wr_data,
    output logic [NBANK-1:0][BANK_W-1:0] bank_q,
    output bank_t                        ctrl_q,
    output bank_t                        ext_q
);
    genvar g;
    generate
        for (g = 0; g < NBANK; g++) begin : g_bank
            // Store one bank register on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g))
                    bank_q[g] <= wr_data;
            end

            // R2: a write to bank register g lands one edge later
            assert_bank_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == SEL_W'(g)) |=> (bank_q[g] == $past(wr_data)));
        end
    endgenerate

    // Store the control register and the extension value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ext_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTRL) ctrl_q <= wr_data;
            if (wr_sel == SEL_EXT)  ext_q  <= wr_data;
        end
    end

    // R1: reset leaves every register at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (bank_q == '0 && ctrl_q == '0 && ext_q == '0));

    // R2: no write, or an unused select code, leaves the registers unchanged
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel > SEL_EXT) |=>
            ($stable(bank_q) && $stable(ctrl_q) && $stable(ext_q)));
endmodule

// File: rtl/prg_bank_calc.sv
// Module: computes the four 8 KB slot pages and the 0x6000 window page
// from the registers, for all four modes. Purely combinational; clk and
// rst_n only time the checks.
module prg_bank_calc
    import prg_bank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NBANK-1:0][BANK_W-1:0] bank_q,
    input  bank_t                        ctrl_q,
    input  bank_t                        ext_q,
    output logic [NSLOT-1:0][BANK_W-1:0] slot_bank,
    output bank_t                        win_bank
);
    prg_mode_e mode;
    bank_t     top_bank;
    bank_t     ext_sh1;
    bank_t     ext_sh2;
    bank_t     blk32;
    bank_t     blk16_lo;
    bank_t     blk16_hi;

    // Decode the mode and form the shared block numbers.
    always_comb begin
        mode     = prg_mode_e'(ctrl_q[1:0]);
        top_bank = ctrl_q[2] ? bank_q[3] : '1;
        ext_sh1  = ext_q >> 1;
        ext_sh2  = ext_q >> 2;
        blk32    = (top_bank & 8'h0F) | ext_sh2;
        blk16_lo = (bank_q[1] & 8'h1F) | ext_sh1;
        blk16_hi = (top_bank & 8'h1F) | ext_sh1;
    end

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            bank_t src;
            bank_t blk16;
            // Pick the source value and mode-specific page for slot s.
            always_comb begin
                src   = (s == NSLOT-1) ? top_bank : bank_q[s];
                blk16 = (s < 2) ? blk16_lo : blk16_hi;
                case (mode)
                    MODE_32K:    slot_bank[s] = BANK_W'({blk32, 2'(s)});
                    MODE_16K:    slot_bank[s] = BANK_W'({blk16, 1'(s)});
                    MODE_8K:     slot_bank[s] = src | ext_q;
                    default:     slot_bank[s] = (bank_t'({1'b0, rev7(src[6:0])}) & 8'h3F) | ext_q;
                endcase
            end

            // R4: in 32 KB mode the slot position forms the low page bits
            assert_slot_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MODE_32K) |-> (slot_bank[s][1:0] == 2'(s)));

            // R9: in the plain 8 KB mode every extension bit shows in the page
            assert_ext_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MODE_8K) |-> ((slot_bank[s] & ext_q) == ext_q));
        end
    endgenerate

    // Form the 0x6000 window page from bank register 3.
    always_comb begin
        case (mode)
            MODE_32K: win_bank = ((BANK_W'(bank_q[3] << 2) + 8'd3) & 8'h3F) | ext_sh2;
            MODE_16K: win_bank = ((BANK_W'(bank_q[3] << 1) + 8'd1) & 8'h1F) | ext_sh1;
            MODE_8K:  win_bank = bank_q[3] | ext_q;
            default:  win_bank = (bank_t'({1'b0, rev7(bank_q[3][6:0])}) & 8'h3F) | ext_q;
        endcase
    end

    // R8: a fixed top bank in plain 8 KB mode reads all ones
    assert_top_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_8K && !ctrl_q[2]) |-> (slot_bank[NSLOT-1] == '1));

    // R7: with a switchable top, reversed mode maps 0xE000 like the window
    assert_rev_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_8K_REV && ctrl_q[2]) |-> (slot_bank[NSLOT-1] == win_bank));
endmodule

// File: rtl/prg_window_mux.sv
// Module: address decode. Picks the window page or one slot page from the
// top three address bits. Assumes the banked range starts at 0x6000.
module prg_window_mux
    import prg_bank_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PAGE_W-1:0]            cpu_addr_top,
    input  logic [NSLOT-1:0][BANK_W-1:0] slot_bank,
    input  bank_t                        win_bank,
    output logic                         rom_sel,
    output bank_t                        rom_bank
);
    localparam logic [PAGE_W-1:0] WIN_PAGE = 3'd3;

    // Route the page for the current address.
    always_comb begin
        if (cpu_addr_top[PAGE_W-1]) begin
            rom_sel  = 1'b1;
            rom_bank = slot_bank[cpu_addr_top[PAGE_W-2:0]];
        end else if (cpu_addr_top == WIN_PAGE) begin
            rom_sel  = 1'b1;
            rom_bank = win_bank;
        end else begin
            rom_sel  = 1'b0;
            rom_bank = '0;
        end
    end

    // R3: below the banked range the output is idle
    assert_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_top < WIN_PAGE) |-> (!rom_sel && rom_bank == '0));
endmodule

// File: rtl/prg_bank_sel.sv
// Module: top of the program ROM bank selector. Registers are written
// through a strobe; the page for the current address is combinational.
module prg_bank_sel
    import prg_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] cpu_addr_top,
    output logic              rom_sel,
    output logic [BANK_W-1:0] rom_bank
);
    logic [NBANK-1:0][BANK_W-1:0] bank_q;
    logic [NSLOT-1:0][BANK_W-1:0] slot_bank;
    bank_t ctrl_q;
    bank_t ext_q;
    bank_t win_bank;

    prg_bank_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bank_q(bank_q), .ctrl_q(ctrl_q), .ext_q(ext_q)
    );

    prg_bank_calc u_calc (
        .clk(clk), .rst_n(rst_n), .bank_q(bank_q), .ctrl_q(ctrl_q),
        .ext_q(ext_q), .slot_bank(slot_bank), .win_bank(win_bank)
    );

    prg_window_mux u_mux (
        .clk(clk), .rst_n(rst_n), .cpu_addr_top(cpu_addr_top),
        .slot_bank(slot_bank), .win_bank(win_bank),
        .rom_sel(rom_sel), .rom_bank(rom_bank)
    );
endmodule

// File: tb/tb_prg_bank_sel.sv
module tb_prg_bank_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] cpu_addr_top = '0;
    logic       rom_sel;
    logic [7:0] rom_bank;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prg_bank_sel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_addr_top(cpu_addr_top),
        .rom_sel(rom_sel), .rom_bank(rom_bank)
    );

    // Fields: req, bank0, bank1, bank2, bank3, ctrl, ext, address, expected page
    localparam int NV = 20;
    localparam logic [75:0] VEC [NV] = '{
        {4'd4, 8'h00, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 16'hA000, 8'h3D}, // R4
        {4'd4, 8'h00, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 16'h6000, 8'h17}, // R4
        {4'd9, 8'h00, 8'h00, 8'h00, 8'h12, 8'h04, 8'h40, 16'hC000, 8'h4A}, // R9
        {4'd9, 8'h00, 8'h00, 8'h00, 8'h12, 8'h04, 8'h40, 16'h6000, 8'h1B}, // R9
        {4'd5, 8'h00, 8'h23, 8'h00, 8'h00, 8'h01, 8'h00, 16'hA000, 8'h07}, // R5
        {4'd5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h20, 16'hE000, 8'h3F}, // R5
        {4'd5, 8'h00, 8'h00, 8'h00, 8'h13, 8'h05, 8'h20, 16'h6000, 8'h17}, // R5
        {4'd5, 8'h00, 8'h02, 8'h00, 8'h13, 8'h05, 8'h20, 16'h8000, 8'h24}, // R5
        {4'd6, 8'h11, 8'h22, 8'h33, 8'h44, 8'h02, 8'h80, 16'h8000, 8'h91}, // R6
        {4'd6, 8'h11, 8'h22, 8'h33, 8'h44, 8'h02, 8'h80, 16'hC000, 8'hB3}, // R6
        {4'd8, 8'h11, 8'h22, 8'h33, 8'h44, 8'h02, 8'h80, 16'hE000, 8'hFF}, // R8
        {4'd6, 8'h11, 8'h22, 8'h33, 8'h44, 8'h02, 8'h80, 16'h6000, 8'hC4}, // R6
        {4'd8, 8'h11, 8'h22, 8'h33, 8'h44, 8'h06, 8'h80, 16'hE000, 8'hC4}, // R8
        {4'd7, 8'h01, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 16'h8000, 8'h00}, // R7
        {4'd7, 8'h02, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 16'h8000, 8'h20}, // R7
        {4'd7, 8'h00, 8'h40, 8'h00, 8'h00, 8'h03, 8'h80, 16'hA000, 8'h81}, // R7
        {4'd7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 16'hE000, 8'h3F}, // R7
        {4'd7, 8'h00, 8'h00, 8'h00, 8'h0C, 8'h07, 8'h00, 16'hE000, 8'h18}, // R7
        {4'd7, 8'h00, 8'h00, 8'h00, 8'h0C, 8'h07, 8'h00, 16'h6000, 8'h18}, // R7
        {4'd7, 8'h00, 8'h00, 8'h30, 8'h00, 8'h03, 8'h00, 16'hC000, 8'h06}  // R7
    };

    task automatic check(input string req, input logic sel_exp, input logic [7:0] bank_exp);
        checks++;
        if (rom_sel !== sel_exp || rom_bank !== bank_exp) begin
            errors++;
            $display("FAIL %s: rom_sel=%0b rom_bank=%02h expected rom_sel=%0b rom_bank=%02h",
                     req, rom_sel, rom_bank, sel_exp, bank_exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [2:0] page);
        cpu_addr_top = page;
        #2;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset map
        look(3'd4); check("R1", 1'b1, 8'h3C);
        look(3'd7); check("R1", 1'b1, 8'h3F);
        look(3'd3); check("R1", 1'b1, 8'h03);
        // R3: outside the banked range
        look(3'd2); check("R3", 1'b0, 8'h00);
        look(3'd0); check("R3", 1'b0, 8'h00);
        // R2: unused select codes change nothing
        wr(3'd6, 8'hFF); wr(3'd7, 8'h03);
        look(3'd4); check("R2", 1'b1, 8'h3C);
        look(3'd3); check("R2", 1'b1, 8'h03);
        // R2: old page holds until the storing edge
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h02;
        look(3'd4); check("R2", 1'b1, 8'h3C);
        @(negedge clk);
        wr_en = 1'b0;
        look(3'd4); check("R2", 1'b1, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VEC[i][71:64]);
            wr(3'd1, VEC[i][63:56]);
            wr(3'd2, VEC[i][55:48]);
            wr(3'd3, VEC[i][47:40]);
            wr(3'd4, VEC[i][39:32]);
            wr(3'd5, VEC[i][31:24]);
            look(VEC[i][23:21]);
            check($sformatf("R%0d vector %0d", VEC[i][75:72], i), 1'b1, VEC[i][7:0]);
        end

        // R1: reset in the middle of a run restores the reset map
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(3'd5); check("R1", 1'b1, 8'h3D);
        look(3'd3); check("R1", 1'b1, 8'h03);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule